// File: doc/BRIEF.md
# Test-Mode Clock Enable and Control

This block sits beside a small bus peripheral and decides how that peripheral runs under test. Through a set of bus-visible test registers it provides three things. The first is one clock-enable that gates all of the peripheral's functional flops. The second is a registered soft reset that clears the functional logic while leaving the test registers as they are. The third is an input multiplexer that feeds the peripheral's two serial input lines, clock and data, either from the pads or from a stimulus register that software writes.

In normal operation the clock-enable stays high. With test mode and test clocking both on, the enable can run in one of two modes. In the first it pulses once in the access phase of every bus transfer. In the second it pulses only in the access phase of a transfer to a dedicated window of word addresses. This lets a tester single-step the functional logic from the bus, one cycle per transfer, with no side effect on any register. The peripheral itself is outside this block.

Top module: `tmode_ctrl`

## Requirements
- R1: After the bus reset, the control, mode and stimulus registers read 0x00, the clock-enable is high, and the soft reset is high while the bus reset is held and low once it is released.
- R2: The clock-enable is continuously high when control bit 0 (test enable) is 0, or when bit 0 is 1 and bit 1 (test clocking) is 0. In both cases bit 2 has no effect.
- R3: With control bits 0 and 1 set and bit 2 clear (strobe mode), the clock-enable is high in the access phase (select and enable both high) of every transfer, read or write, to any address, and low in the setup phase and between transfers.
- R4: With control bits 0, 1 and 2 set (window mode), the clock-enable is high only in the access phase of a transfer whose address lies from 0x40 to 0x7C. It is low for all other addresses, including 0x3C and 0x80.
- R5: The control register is at offset 0x80, with test enable at bit 0, test clocking at bit 1, window mode at bit 2, soft reset at bit 3 and input override at bit 4. Setting only bit 4 leaves the clock-enable high and the soft reset low.
- R6: One cycle after control bit 3 becomes 1, the soft reset output goes high. It goes low one cycle after bit 3 is cleared. The test registers keep their contents throughout.
- R7: With control bit 4 set, stimulus register (offset 0x88) bit 0 drives the internal clock line and bit 1 drives the internal data line. With bit 4 clear, the clock and data pads drive them.
- R8: Reserved register bits read as 0 and writes to them are dropped. Reads from the window return 0.
- R9: The mode register at offset 0x84 stores four bits and reads them back, so writing 0xFF reads back 0x0F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Bus reset, active low, asynchronous |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | Bus write when high |
| paddr | input | 8 | Bus byte address |
| pwdata | input | 8 | Bus write data |
| prdata | output | 8 | Bus read data |
| pad_clk_i | input | 1 | Serial clock from the pad |
| pad_dat_i | input | 1 | Serial data from the pad |
| clk_en_o | output | 1 | Clock-enable for the functional logic |
| func_rst_o | output | 1 | Soft reset for the functional logic, active high |
| int_clk_o | output | 1 | Internal serial clock line |
| int_dat_o | output | 1 | Internal serial data line |

## Verification
The hardest case to reach from the ports is window mode. There, the enable must stay low for a transfer to a neighbouring address while it still pulses for a transfer inside the window. Because the control register that selects the mode is itself written over the bus, the stimulus table reprograms the control register before each probe transfer. It then samples the enable in both the setup and the access phase of that probe, and it includes the addresses just below, at and just above each edge of the window. The soft reset is checked by setting it and then reading the stimulus register back, to show the test registers survived.

// File: rtl/tmode_pkg.sv
package tmode_pkg;

   // Control register layout; field order fixes the bit positions (bit 0 last).
   typedef struct packed {
      logic in_sel;   // bit 4: internal inputs from stimulus register
      logic trst;     // bit 3: soft reset of functional logic
      logic winmode;  // bit 2: enable only on window accesses
      logic tcken;    // bit 1: test clocking on
      logic ten;      // bit 0: test mode on
   } ctrl_t;

   localparam int unsigned CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/tmode_regs.sv
module tmode_regs
   import tmode_pkg::*;
#(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned MODE_W   = 4,
   parameter int unsigned STIM_W   = 2,
   parameter int unsigned CTRL_OFS = 'h80,
   parameter int unsigned MODE_OFS = 'h84,
   parameter int unsigned STIM_OFS = 'h88
) (
   input  logic              pclk,
   input  logic              presetn,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [DATA_W-1:0] pwdata,
   output logic [DATA_W-1:0] prdata,
   output ctrl_t             ctrl,
   output logic [STIM_W-1:0] stim
);

   localparam int unsigned MAXW = (MODE_W > CTRL_W) ? MODE_W : CTRL_W;

   if (DATA_W < MAXW || DATA_W < STIM_W) begin : g_bad_width
      $error("tmode_regs: DATA_W too small for the test registers");
   end

   logic              wr_acc;
   logic              hit_ctrl, hit_mode, hit_stim;
   logic [MODE_W-1:0] mode_q;
   logic              unused_wdata;

   assign wr_acc   = psel & penable & pwrite;
   assign hit_ctrl = (paddr == ADDR_W'(CTRL_OFS));
   assign hit_mode = (paddr == ADDR_W'(MODE_OFS));
   assign hit_stim = (paddr == ADDR_W'(STIM_OFS));
   assign unused_wdata = ^pwdata;

   always_ff @(posedge pclk or negedge presetn) begin
      if (!presetn) begin
         ctrl   <= '0;
         mode_q <= '0;
         stim   <= '0;
      end else if (wr_acc) begin
         if (hit_ctrl) ctrl   <= ctrl_t'(pwdata[CTRL_W-1:0]);
         if (hit_mode) mode_q <= pwdata[MODE_W-1:0];
         if (hit_stim) stim   <= pwdata[STIM_W-1:0];
      end
   end

   always_comb begin
      prdata = '0;
      if (psel && !pwrite) begin
         if (hit_ctrl)      prdata[CTRL_W-1:0] = ctrl;
         else if (hit_mode) prdata[MODE_W-1:0] = mode_q;
         else if (hit_stim) prdata[STIM_W-1:0] = stim;
      end
   end

   // R6/R8: test registers change only through a bus write
   p_ctrl_hold_r6: assert property (@(posedge pclk) disable iff (!presetn)
      !wr_acc |=> $stable(ctrl));
   p_stim_hold_r6: assert property (@(posedge pclk) disable iff (!presetn)
      !wr_acc |=> $stable(stim));
   p_rd_idle_r8: assert property (@(posedge pclk) disable iff (!presetn)
      !psel |-> (prdata == '0));

endmodule

// File: rtl/tmode_clken.sv
module tmode_clken
   import tmode_pkg::*;
#(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned WIN_LO = 'h40,
   parameter int unsigned WIN_HI = 'h7C
) (
   input  logic              pclk,
   input  logic              presetn,
   input  ctrl_t             ctrl,
   input  logic              psel,
   input  logic              penable,
   input  logic [ADDR_W-1:0] paddr,
   output logic              clk_en
);

   if (WIN_HI < WIN_LO) begin : g_bad_win
      $error("tmode_clken: window upper bound below lower bound");
   end

   logic win_hit;
   logic acc_phase;
   logic gated;

   if (WIN_LO == WIN_HI) begin : g_win_single
      assign win_hit = (paddr == ADDR_W'(WIN_LO));
   end else begin : g_win_range
      assign win_hit = (paddr >= ADDR_W'(WIN_LO)) && (paddr <= ADDR_W'(WIN_HI));
   end

   assign acc_phase = psel & penable;
   assign gated     = ctrl.ten & ctrl.tcken;

   always_comb begin
      if (!gated)            clk_en = 1'b1;
      else if (!ctrl.winmode) clk_en = acc_phase;
      else                   clk_en = acc_phase & win_hit;
   end

   p_free_run_r2: assert property (@(posedge pclk) disable iff (!presetn)
      !(ctrl.ten && ctrl.tcken) |-> clk_en);
   p_strobe_r3: assert property (@(posedge pclk) disable iff (!presetn)
      (ctrl.ten && ctrl.tcken && !ctrl.winmode && psel && penable) |-> clk_en);
   p_idle_low_r3: assert property (@(posedge pclk) disable iff (!presetn)
      (ctrl.ten && ctrl.tcken && !(psel && penable)) |-> !clk_en);
   p_win_only_r4: assert property (@(posedge pclk) disable iff (!presetn)
      (ctrl.ten && ctrl.tcken && ctrl.winmode && clk_en)
         |-> (paddr >= ADDR_W'(WIN_LO) && paddr <= ADDR_W'(WIN_HI)));

endmodule

// File: rtl/tmode_rstgen.sv
module tmode_rstgen
   import tmode_pkg::*;
(
   input  logic  pclk,
   input  logic  presetn,
   input  ctrl_t ctrl,
   output logic  func_rst
);

   always_ff @(posedge pclk or negedge presetn) begin
      if (!presetn) func_rst <= 1'b1;
      else          func_rst <= ctrl.trst;
   end

   p_trst_set_r6: assert property (@(posedge pclk) disable iff (!presetn)
      ctrl.trst |=> func_rst);
   p_trst_clr_r6: assert property (@(posedge pclk) disable iff (!presetn)
      !ctrl.trst |=> !func_rst);

endmodule

// File: rtl/tmode_inmux.sv
module tmode_inmux #(
   parameter int unsigned N_LINES = 2
) (
   input  logic               sel,
   input  logic [N_LINES-1:0] pad_i,
   input  logic [N_LINES-1:0] stim_i,
   output logic [N_LINES-1:0] line_o
);

   if (N_LINES == 0) begin : g_bad_lines
      $error("tmode_inmux: N_LINES must be nonzero");
   end

   for (genvar i = 0; i < N_LINES; i++) begin : g_line
      assign line_o[i] = sel ? stim_i[i] : pad_i[i];
   end

endmodule

// File: rtl/tmode_ctrl.sv
module tmode_ctrl
   import tmode_pkg::*;
#(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned MODE_W   = 4,
   parameter int unsigned CTRL_OFS = 'h80,
   parameter int unsigned MODE_OFS = 'h84,
   parameter int unsigned STIM_OFS = 'h88,
   parameter int unsigned WIN_LO   = 'h40,
   parameter int unsigned WIN_HI   = 'h7C
) (
   input  logic              pclk,
   input  logic              presetn,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [DATA_W-1:0] pwdata,
   output logic [DATA_W-1:0] prdata,
   input  logic              pad_clk_i,
   input  logic              pad_dat_i,
   output logic              clk_en_o,
   output logic              func_rst_o,
   output logic              int_clk_o,
   output logic              int_dat_o
);

   localparam int unsigned N_LINES = 2;   // line 0 = clock, line 1 = data

   ctrl_t              ctrl;
   logic [N_LINES-1:0] stim;
   logic [N_LINES-1:0] lines;

   tmode_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MODE_W(MODE_W), .STIM_W(N_LINES),
      .CTRL_OFS(CTRL_OFS), .MODE_OFS(MODE_OFS), .STIM_OFS(STIM_OFS)
   ) u_regs (
      .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
      .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
      .ctrl(ctrl), .stim(stim)
   );

   tmode_clken #(.ADDR_W(ADDR_W), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u_clken (
      .pclk(pclk), .presetn(presetn), .ctrl(ctrl), .psel(psel),
      .penable(penable), .paddr(paddr), .clk_en(clk_en_o)
   );

   tmode_rstgen u_rst (
      .pclk(pclk), .presetn(presetn), .ctrl(ctrl), .func_rst(func_rst_o)
   );

   tmode_inmux #(.N_LINES(N_LINES)) u_mux (
      .sel(ctrl.in_sel), .pad_i({pad_dat_i, pad_clk_i}), .stim_i(stim),
      .line_o(lines)
   );

   assign int_clk_o = lines[0];
   assign int_dat_o = lines[1];

   p_override_r7: assert property (@(posedge pclk) disable iff (!presetn)
      ctrl.in_sel |-> (int_clk_o == stim[0] && int_dat_o == stim[1]));
   p_pads_r7: assert property (@(posedge pclk) disable iff (!presetn)
      !ctrl.in_sel |-> (int_clk_o == pad_clk_i && int_dat_o == pad_dat_i));

endmodule

// File: tb/sim_tmode_ctrl.sv
`timescale 1ns/1ps
module sim_tmode_ctrl;

   logic       pclk = 1'b0;
   logic       presetn = 1'b0;
   logic       psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
   logic [7:0] paddr = '0, pwdata = '0;
   logic [7:0] prdata;
   logic       pad_clk_i = 1'b0, pad_dat_i = 1'b0;
   logic       clk_en_o, func_rst_o, int_clk_o, int_dat_o;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #2 pclk = ~pclk;   // 250 MHz

   tmode_ctrl u0 (
      .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
      .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
      .pad_clk_i(pad_clk_i), .pad_dat_i(pad_dat_i), .clk_en_o(clk_en_o),
      .func_rst_o(func_rst_o), .int_clk_o(int_clk_o), .int_dat_o(int_dat_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // One bus transfer; returns enable seen in setup and access phase
   task automatic xfer(input logic [7:0] a, input logic w, input logic [7:0] d,
                       output logic [7:0] rd, output logic ce_s, output logic ce_a);
      @(negedge pclk);
      psel = 1'b1; penable = 1'b0; pwrite = w; paddr = a; pwdata = d;
      #1 ce_s = clk_en_o;
      @(negedge pclk);
      penable = 1'b1;
      #1 ce_a = clk_en_o; rd = prdata;
      @(negedge pclk);
      psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      logic [7:0] r; logic s, x;
      xfer(a, 1'b1, d, r, s, x);
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] r);
      logic s, x;
      xfer(a, 1'b0, 8'h00, r, s, x);
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   // {ctrl[7:0], addr[7:0], 5'b0, write, exp_setup, exp_access}
   localparam int NV = 13;
   localparam logic [23:0] VEC [NV] = '{
      {8'h00, 8'h84, 5'd0, 1'b0, 1'b1, 1'b1},  // R2 test mode off
      {8'h01, 8'h88, 5'd0, 1'b0, 1'b1, 1'b1},  // R2 clocking off
      {8'h05, 8'h40, 5'd0, 1'b0, 1'b1, 1'b1},  // R2 bit2 ignored
      {8'h03, 8'h84, 5'd0, 1'b0, 1'b0, 1'b1},  // R3 read
      {8'h03, 8'h88, 5'd0, 1'b1, 1'b0, 1'b1},  // R3 write
      {8'h03, 8'h20, 5'd0, 1'b0, 1'b0, 1'b1},  // R3 unmapped
      {8'h07, 8'h40, 5'd0, 1'b0, 1'b0, 1'b1},  // R4 low edge
      {8'h07, 8'h7C, 5'd0, 1'b0, 1'b0, 1'b1},  // R4 high edge
      {8'h07, 8'h5C, 5'd0, 1'b1, 1'b0, 1'b1},  // R4 write inside
      {8'h07, 8'h84, 5'd0, 1'b0, 1'b0, 1'b0},  // R4 outside
      {8'h07, 8'h3C, 5'd0, 1'b0, 1'b0, 1'b0},  // R4 below
      {8'h07, 8'h80, 5'd0, 1'b0, 1'b0, 1'b0},  // R4 above
      {8'h06, 8'h84, 5'd0, 1'b0, 1'b1, 1'b1}   // R2 no test enable
   };

   initial begin
      repeat (200000) @(posedge pclk);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog actual=running expected=done");
         finish_run();
      end
   end

   initial begin
      logic [7:0] r;
      logic s, a;
      // R1: during reset
      repeat (3) @(negedge pclk);
      chk("R1 rst held func_rst", func_rst_o, 1);
      chk("R1 rst held clk_en", clk_en_o, 1);
      presetn = 1'b1;
      repeat (2) @(negedge pclk);
      chk("R1 func_rst released", func_rst_o, 0);
      rd(8'h80, r); chk("R1 ctrl reset", r, 8'h00);
      rd(8'h84, r); chk("R1 mode reset", r, 8'h00);
      rd(8'h88, r); chk("R1 stim reset", r, 8'h00);

      // vector table
      for (int i = 0; i < NV; i++) begin
         wr(8'h80, VEC[i][23:16]);
         xfer(VEC[i][15:8], VEC[i][2], 8'h00, r, s, a);
         chk($sformatf("R2/R3/R4 vec%0d setup", i), s, VEC[i][1]);
         chk($sformatf("R2/R3/R4 vec%0d access", i), a, VEC[i][0]);
      end

      // R4: consecutive window transfers each pulse
      wr(8'h80, 8'h07);
      for (int k = 0; k < 3; k++) begin
         xfer(8'h44 + 8'(k*4), 1'b0, 8'h00, r, s, a);
         chk("R4 back-to-back pulse", {s, a}, 2'b01);
      end

      // R8: window reads zero, reserved bits dropped
      wr(8'h80, 8'h00);
      rd(8'h60, r); chk("R8 window read", r, 8'h00);
      wr(8'h88, 8'hFE); rd(8'h88, r); chk("R8 stim reserved", r, 8'h02);
      // R9
      wr(8'h84, 8'hFF); rd(8'h84, r); chk("R9 mode readback", r, 8'h0F);

      // R7: pads drive when override off
      pad_clk_i = 1'b1; pad_dat_i = 1'b0; #1;
      chk("R7 pads clk", int_clk_o, 1); chk("R7 pads dat", int_dat_o, 0);
      // R5: only override set
      wr(8'h80, 8'h10);
      @(negedge pclk);
      chk("R5 override only clk_en", clk_en_o, 1);
      chk("R5 override only func_rst", func_rst_o, 0);
      chk("R7 stim dat", int_dat_o, 1); chk("R7 stim clk", int_clk_o, 0);
      pad_dat_i = 1'b0; pad_clk_i = 1'b1; #1;
      chk("R7 pads ignored", {int_dat_o, int_clk_o}, 2'b10);
      wr(8'h88, 8'h01); #1;
      chk("R7 stim swap", {int_dat_o, int_clk_o}, 2'b01);

      // R6: soft reset with test registers kept
      wr(8'h88, 8'h03);
      wr(8'h80, 8'h08);
      @(negedge pclk);
      chk("R6 func_rst set", func_rst_o, 1);
      rd(8'h88, r); chk("R6 stim kept", r, 8'h03);
      rd(8'h84, r); chk("R6 mode kept", r, 8'h0F);
      rd(8'h80, r); chk("R6 ctrl kept", r, 8'h08);
      wr(8'h80, 8'h00);
      @(negedge pclk);
      chk("R6 func_rst clear", func_rst_o, 0);
      // R5/R8: full write keeps only five bits
      wr(8'h80, 8'hFF); rd(8'h80, r); chk("R5 ctrl bits", r, 8'h1F);

      done = 1'b1;
      finish_run();
   end

endmodule